// File: doc/BRIEF.md
# Crosspoint Route Configuration Register

This block holds the routing program of an eight-output, sixteen-input crosspoint switch. Each output owns a five-bit route word: a four-bit source select and an enable bit. The words are staged in a shadow register that can be loaded in two ways. In serial mode a long bit stream is shifted through the whole register. In parallel mode a single addressed output's word is written in one step. A second rank, the active route rank, copies the shadow register whenever both the update strobe and the chip select are low. It holds its contents otherwise, so a new program can be staged without disturbing the live matrix. The last shadow stage drives a serial output, which lets several devices share one programming stream in a chain.

All logic runs on one system clock `clk`. The programming clock `pg_clk` is an ordinary input sampled by `clk`. A programming event happens on the `clk` edge where `pg_clk` is seen low after being seen high at the previous edge. The active-high synchronous reset only turns every output off. Stored source selections survive it.

Top module: `xbar_cfg_core`

## Requirements
- R1: With `ser_par` = 0 and `ce_n` = 0, each programming event shifts the shadow register by one stage toward the serial output and takes `sdi` into the first stage.
- R2: A serial frame is 80 bits. The first 40 bits are padding. Then come the words for output 7 down to output 0. Each word is sent enable bit first, then select bit 3, 2, 1, 0. After the frame and an update, output k shows that select on `route_sel[4k+3:4k]` and that enable on `route_en[k]`.
- R3: With `ser_par` = 1 and `ce_n` = 0, a programming event writes `din` into the word of the output named by `addr`. `din[4]` is the enable and `din[3:0]` the select. The other words are left unchanged and `sdo` does not change.
- R4: While `ce_n` = 1, programming events are ignored in both modes. The shadow register, `sdo` and the routes are unchanged.
- R5: On every `clk` edge where `upd_n` = 0 and `ce_n` = 0, the active rank takes the shadow contents, visible one cycle later. Otherwise it holds its value.
- R6: Several parallel writes made while `upd_n` = 1 leave the outputs untouched. They all appear together at the first update.
- R7: `rst` = 1 clears every bit of `route_en` at the next edge and leaves `route_sel` and the shadow register unchanged.
- R8: `sdo` is the last shadow stage. After a further j serial shifts it shows bit j of the earlier frame, which lets devices be chained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; disables all outputs |
| pg_clk | input | 1 | Programming clock; its falling transition triggers a load |
| ce_n | input | 1 | Active-low chip select for loading and updating |
| upd_n | input | 1 | Active-low update strobe for the active rank |
| ser_par | input | 1 | Load mode: 0 serial, 1 parallel |
| sdi | input | 1 | Serial data input |
| addr | input | 3 | Output index for a parallel write |
| din | input | 5 | Parallel word: bit 4 enable, bits 3:0 select |
| route_sel | output | 32 | Active source select, four bits per output |
| route_en | output | 8 | Active enable, one bit per output |
| sdo | output | 1 | Serial output from the last shadow stage |

## Verification
The bench follows each serial frame with a second frame. It watches `sdo` replay the first frame bit by bit, which would expose a reversed shift direction or a word order within a group that differs from the one stated. It issues programming events with `ce_n` high, so a design that ignored the select would shift or write the shadow register. Parallel writes are staged behind a high update strobe. A design that wrote straight to the active rank would show them early, and one that shifted on a parallel write would move `sdo`. Reset is applied to a programmed matrix, so a reset that also cleared the selects or the shadow register would show wrong routes after the next update.

// File: rtl/xbar_cfg_pkg.sv
package xbar_cfg_pkg;

  typedef enum logic {
    LOAD_SERIAL   = 1'b0,
    LOAD_PARALLEL = 1'b1
  } load_mode_e;

  // Position of the lowest bit of an output's word in the shadow register.
  function automatic int word_base(input int idx, input int word_w);
    return idx * word_w;
  endfunction

endpackage

// File: rtl/xbar_fall_detect.sv
module xbar_fall_detect (
  input  logic clk,
  input  logic rst,
  input  logic pg_clk,
  output logic fall
);

  logic pg_q;

  // Idle level of the programming clock is high.
  always_ff @(posedge clk) begin
    if (rst) pg_q <= 1'b1;
    else     pg_q <= pg_clk;
  end

  assign fall = pg_q & ~pg_clk;

endmodule

// File: rtl/xbar_shadow_rank.sv
module xbar_shadow_rank
  import xbar_cfg_pkg::*;
#(
  parameter int N_OUT    = 8,
  parameter int SEL_W    = 4,
  parameter int PAD_BITS = 40,
  localparam int WORD_W     = SEL_W + 1,
  localparam int ROUTE_BITS = N_OUT * WORD_W,
  localparam int FRAME      = ROUTE_BITS + PAD_BITS,
  localparam int ADDR_W     = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic                  clk,
  input  logic                  fall,
  input  logic                  ce_n,
  input  load_mode_e            mode,
  input  logic                  sdi,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [WORD_W-1:0]     din,
  output logic [ROUTE_BITS-1:0] route_bits,
  output logic                  sdo
);

  logic [FRAME-1:0] chain_q;
  logic [FRAME-1:0] chain_shift;
  logic             do_load;
  logic             do_serial;

  assign do_load   = fall & ~ce_n;
  assign do_serial = do_load & (mode == LOAD_SERIAL);
  assign chain_shift = {chain_q[FRAME-2:0], sdi};

  genvar g;
  generate
    for (g = 0; g < N_OUT; g++) begin : g_word
      localparam int LSB = word_base(g, WORD_W);
      logic hit;
      assign hit = do_load && (mode == LOAD_PARALLEL) && (addr == ADDR_W'(g));
      always_ff @(posedge clk) begin
        if (do_serial)
          chain_q[LSB +: WORD_W] <= chain_shift[LSB +: WORD_W];
        else if (hit)
          chain_q[LSB +: WORD_W] <= din;
      end
    end

    if (PAD_BITS > 0) begin : g_pad
      always_ff @(posedge clk) begin
        if (do_serial)
          chain_q[FRAME-1:ROUTE_BITS] <= chain_shift[FRAME-1:ROUTE_BITS];
      end
    end
  endgenerate

  assign route_bits = chain_q[ROUTE_BITS-1:0];
  assign sdo        = chain_q[FRAME-1];

endmodule

// File: rtl/xbar_route_rank.sv
module xbar_route_rank #(
  parameter int N_OUT = 8,
  parameter int SEL_W = 4,
  localparam int WORD_W     = SEL_W + 1,
  localparam int ROUTE_BITS = N_OUT * WORD_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [ROUTE_BITS-1:0]  route_bits,
  output logic [N_OUT*SEL_W-1:0] route_sel,
  output logic [N_OUT-1:0]       route_en
);

  genvar g;
  generate
    for (g = 0; g < N_OUT; g++) begin : g_out
      localparam int LSB = g * WORD_W;

      // Enable is the only state touched by reset.
      always_ff @(posedge clk) begin
        if (rst)       route_en[g] <= 1'b0;
        else if (load) route_en[g] <= route_bits[LSB + SEL_W];
      end

      always_ff @(posedge clk) begin
        if (!rst && load)
          route_sel[g*SEL_W +: SEL_W] <= route_bits[LSB +: SEL_W];
      end
    end
  endgenerate

endmodule

// File: rtl/xbar_cfg_core.sv
module xbar_cfg_core
  import xbar_cfg_pkg::*;
#(
  parameter int N_OUT    = 8,
  parameter int SEL_W    = 4,
  parameter int PAD_BITS = 40,
  localparam int WORD_W     = SEL_W + 1,
  localparam int ROUTE_BITS = N_OUT * WORD_W,
  localparam int ADDR_W     = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pg_clk,
  input  logic                   ce_n,
  input  logic                   upd_n,
  input  logic                   ser_par,
  input  logic                   sdi,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [WORD_W-1:0]      din,
  output logic [N_OUT*SEL_W-1:0] route_sel,
  output logic [N_OUT-1:0]       route_en,
  output logic                   sdo
);

  logic                  pg_fall;
  logic                  upd_load;
  logic [ROUTE_BITS-1:0] route_bits;
  load_mode_e            mode;

  assign mode     = load_mode_e'(ser_par);
  assign upd_load = ~upd_n & ~ce_n;

  xbar_fall_detect u_edge (
    .clk    (clk),
    .rst    (rst),
    .pg_clk (pg_clk),
    .fall   (pg_fall)
  );

  xbar_shadow_rank #(
    .N_OUT    (N_OUT),
    .SEL_W    (SEL_W),
    .PAD_BITS (PAD_BITS)
  ) u_shadow (
    .clk        (clk),
    .fall       (pg_fall),
    .ce_n       (ce_n),
    .mode       (mode),
    .sdi        (sdi),
    .addr       (addr),
    .din        (din),
    .route_bits (route_bits),
    .sdo        (sdo)
  );

  xbar_route_rank #(
    .N_OUT (N_OUT),
    .SEL_W (SEL_W)
  ) u_route (
    .clk        (clk),
    .rst        (rst),
    .load       (upd_load),
    .route_bits (route_bits),
    .route_sel  (route_sel),
    .route_en   (route_en)
  );

endmodule

// File: rtl/xbar_cfg_core_chk.sv
module xbar_cfg_core_chk #(
  parameter int N_OUT = 8,
  parameter int SEL_W = 4,
  parameter int ROUTE_BITS = 40
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   ce_n,
  input logic                   upd_n,
  input logic                   ser_par,
  input logic                   pg_fall,
  input logic [ROUTE_BITS-1:0]  route_bits,
  input logic [N_OUT*SEL_W-1:0] route_sel,
  input logic [N_OUT-1:0]       route_en,
  input logic                   sdo
);

  AST_RST_DISABLES: assert property (@(posedge clk)
    rst |=> (route_en == '0)) else $error("AST_RST_DISABLES"); // R7

  AST_RST_KEEPS_SEL: assert property (@(posedge clk)
    rst |=> $stable(route_sel)) else $error("AST_RST_KEEPS_SEL"); // R7

  AST_HOLD_NO_UPDATE: assert property (@(posedge clk) disable iff (rst)
    (upd_n || ce_n) |=> ($stable(route_sel) && $stable(route_en)))
    else $error("AST_HOLD_NO_UPDATE"); // R5

  AST_CE_FREEZES: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> ($stable(route_bits) && $stable(sdo)))
    else $error("AST_CE_FREEZES"); // R4

  AST_PAR_KEEPS_SDO: assert property (@(posedge clk) disable iff (rst)
    (pg_fall && !ce_n && ser_par) |=> $stable(sdo))
    else $error("AST_PAR_KEEPS_SDO"); // R3

  AST_IDLE_KEEPS_CHAIN: assert property (@(posedge clk) disable iff (rst)
    !pg_fall |=> ($stable(route_bits) && $stable(sdo)))
    else $error("AST_IDLE_KEEPS_CHAIN"); // R1

endmodule

bind xbar_cfg_core xbar_cfg_core_chk #(
  .N_OUT      (N_OUT),
  .SEL_W      (SEL_W),
  .ROUTE_BITS (ROUTE_BITS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ce_n       (ce_n),
  .upd_n      (upd_n),
  .ser_par    (ser_par),
  .pg_fall    (pg_fall),
  .route_bits (route_bits),
  .route_sel  (route_sel),
  .route_en   (route_en),
  .sdo        (sdo)
);

// File: tb/xbar_cfg_core_test.sv
module xbar_cfg_core_test;

  localparam int CLK_PERIOD = 10;
  localparam int NO  = 8;
  localparam int SW  = 4;
  localparam int WW  = 5;
  localparam int PAD = 40;
  localparam int FR  = PAD + NO * WW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pg_clk = 1'b1;
  logic          ce_n = 1'b1;
  logic          upd_n = 1'b1;
  logic          ser_par = 1'b0;
  logic          sdi = 1'b0;
  logic [2:0]    addr = '0;
  logic [4:0]    din = '0;
  logic [NO*SW-1:0] route_sel;
  logic [NO-1:0] route_en;
  logic          sdo;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbar_cfg_core uut (
    .clk(clk), .rst(rst), .pg_clk(pg_clk), .ce_n(ce_n), .upd_n(upd_n),
    .ser_par(ser_par), .sdi(sdi), .addr(addr), .din(din),
    .route_sel(route_sel), .route_en(route_en), .sdo(sdo)
  );

  // ---------------- behavioural reference ----------------
  bit       m_sh[FR];
  bit       m_shk[FR];
  bit       m_en[NO];
  bit       m_enk[NO];
  bit [3:0] m_sel[NO];
  bit       m_selk[NO];
  bit       m_pgq = 1'b1;

  always @(posedge clk) begin
    bit fall;
    fall = m_pgq && !pg_clk;
    if (rst) begin
      for (int k = 0; k < NO; k++) begin m_en[k] = 0; m_enk[k] = 1; end
    end else if (!upd_n && !ce_n) begin
      for (int k = 0; k < NO; k++) begin
        bit ok;
        ok = 1;
        for (int b = 0; b < WW; b++) ok = ok && m_shk[k*WW+b];
        m_en[k] = m_sh[k*WW+4];
        m_enk[k] = m_shk[k*WW+4];
        for (int b = 0; b < SW; b++) m_sel[k][b] = m_sh[k*WW+b];
        m_selk[k] = ok;
      end
    end
    if (fall && !ce_n) begin
      if (!ser_par) begin
        for (int i = FR-1; i > 0; i--) begin
          m_sh[i] = m_sh[i-1]; m_shk[i] = m_shk[i-1];
        end
        m_sh[0] = sdi; m_shk[0] = 1;
      end else begin
        for (int b = 0; b < WW; b++) begin
          m_sh[int'(addr)*WW+b] = din[b]; m_shk[int'(addr)*WW+b] = 1;
        end
      end
    end
    m_pgq = rst ? 1'b1 : pg_clk;
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cyc++;
    for (int k = 0; k < NO; k++) begin
      if (m_enk[k]) begin
        n_chk++;
        if (route_en[k] !== m_en[k]) begin
          n_fail++;
          $display("FAIL R5 cycle %0d out %0d enable: actual %0b expected %0b", cyc, k, route_en[k], m_en[k]);
        end
      end
      if (m_selk[k]) begin
        n_chk++;
        if (route_sel[k*SW +: SW] !== m_sel[k]) begin
          n_fail++;
          $display("FAIL R2 cycle %0d out %0d select: actual %h expected %h", cyc, k, route_sel[k*SW +: SW], m_sel[k]);
        end
      end
    end
    if (m_shk[FR-1]) begin
      n_chk++;
      if (sdo !== m_sh[FR-1]) begin
        n_fail++;
        $display("FAIL R8 cycle %0d sdo: actual %0b expected %0b", cyc, sdo, m_sh[FR-1]);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_pg();
    pg_clk = 1'b0; wait_neg(2);
    pg_clk = 1'b1; wait_neg(2);
  endtask

  task automatic shift_bit(input bit b);
    @(negedge clk);
    sdi = b;
    pulse_pg();
  endtask

  task automatic par_write(input int a, input bit [4:0] w);
    @(negedge clk);
    addr = 3'(a); din = w;
    pulse_pg();
  endtask

  task automatic do_update();
    @(negedge clk);
    upd_n = 1'b0; wait_neg(2);
    upd_n = 1'b1; wait_neg(1);
  endtask

  // frame: padding, then outputs high to low, enable then select MSB..LSB
  function automatic void build_frame(input bit en[NO], input bit [3:0] sel[NO], ref bit q[$]);
    q.delete();
    for (int i = 0; i < PAD; i++) q.push_back(1'b0);
    for (int k = NO-1; k >= 0; k--) begin
      q.push_back(en[k]);
      for (int b = SW-1; b >= 0; b--) q.push_back(sel[k][b]);
    end
  endfunction

  task automatic check_routes(input string tag, input bit en[NO], input bit [3:0] sel[NO]);
    for (int k = 0; k < NO; k++) begin
      check($sformatf("%s out %0d enable", tag, k), int'(route_en[k]), int'(en[k]));
      check($sformatf("%s out %0d select", tag, k), int'(route_sel[k*SW +: SW]), int'(sel[k]));
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    wait_neg(100000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    bit       en_a[NO], en_b[NO], en_c[NO], off[NO];
    bit [3:0] sel_a[NO], sel_b[NO], sel_c[NO];
    bit       fa[$], fb[$];

    for (int k = 0; k < NO; k++) begin
      en_a[k] = (k != 2);  sel_a[k] = 4'(15 - k);
      en_b[k] = (k != 6);  sel_b[k] = 4'(k * 3 + 1);
      off[k] = 0;
    end
    build_frame(en_a, sel_a, fa);
    build_frame(en_b, sel_b, fb);

    wait_neg(3);
    check("R7 reset enables", int'(route_en), 0);
    rst = 1'b0;

    // R1/R2: serial frame A, held behind upd_n high
    ce_n = 1'b0; ser_par = 1'b0;
    foreach (fa[i]) shift_bit(fa[i]);
    check("R5 no update yet, enables", int'(route_en), 0);
    do_update();
    check_routes("R2 frame A", en_a, sel_a);

    // R8: shifting frame B pushes frame A out of sdo in order
    foreach (fb[j]) begin
      @(negedge clk);
      check($sformatf("R8 sdo bit %0d", j), int'(sdo), int'(fa[j]));
      shift_bit(fb[j]);
    end
    check_routes("R5 hold during shift", en_a, sel_a);

    // R4: ce_n high, events and update strobe ignored
    ce_n = 1'b1;
    for (int i = 0; i < 5; i++) shift_bit(1'b1);
    check("R4 sdo unchanged", int'(sdo), int'(fb[0]));
    @(negedge clk); upd_n = 1'b0; wait_neg(3); upd_n = 1'b1;
    check_routes("R4 no update with ce_n high", en_a, sel_a);
    ce_n = 1'b0;
    do_update();
    check_routes("R1 frame B intact", en_b, sel_b);

    // R3/R6: parallel writes staged then applied together
    ser_par = 1'b1;
    en_c = en_b; sel_c = sel_b;
    par_write(3, 5'b1_1010); en_c[3] = 1; sel_c[3] = 4'hA;
    par_write(6, 5'b1_0111); en_c[6] = 1; sel_c[6] = 4'h7;
    par_write(0, 5'b0_0101); en_c[0] = 0; sel_c[0] = 4'h5;
    check("R3 sdo unchanged by parallel", int'(sdo), int'(fb[0]));
    check_routes("R6 staged writes hidden", en_b, sel_b);
    do_update();
    check_routes("R6 staged writes applied", en_c, sel_c);

    // R7: reset disables only
    @(negedge clk); rst = 1'b1; wait_neg(1); rst = 1'b0;
    check_routes("R7 after reset", off, sel_c);
    do_update();
    check_routes("R7 shadow kept", en_c, sel_c);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule